// File: doc/BRIEF.md
# I2C Receive Path with Packet-Error-Checked Acknowledge

This block is the receive datapath of a multi-master I2C controller. It takes the already-synchronised SCL and SDA levels and the START and STOP detect strobes from the bus front end. It shifts in each data byte most significant bit first on SCL rising edges. It then decides whether to pull SDA low during the ninth clock to acknowledge the byte. While bits arrive, a CRC-8 accumulator runs over every byte of the transfer, the address byte included.

Software can arm a flag that marks the next received byte, and every later byte until the next START, as the packet-error-check byte. In slave receive mode, a failed check on such a byte suppresses the acknowledge. In master receive mode, the acknowledge ignores the check result. In both modes a sticky error flag records the mismatch.

The received-byte output is a stream with a valid strobe only. An I2C receiver cannot pause the bus from this point, so there is no back-pressure. The consumer must take `rx_data` in the cycle `rx_valid` is high. `rx_data` then holds its value until the next byte completes.

Top module: `i2c_pec_rx`

## Requirements
- R1: Bits are sampled from `sda_in` on each SCL rising edge, most significant bit first. One clock after the 8th bit is sampled, `rx_valid` is high for exactly one clock and `rx_data` holds the byte.
- R2: In receive mode (`rx_mode`=1) with `ack_dis`=0 and no failing slave check, `sda_pull` goes to 1 while SCL is low before the 9th rising edge. It stays at 1 through the 9th high phase and returns to 0 after SCL falls again.
- R3: With `ack_dis`=1 at byte completion, `sda_pull` stays 0 during the 9th clock (NACK).
- R4: The CRC is CRC-8 with polynomial 0x07 and initial value 0x00, processed MSB first. It covers every byte since the most recent START or repeated START, and `start_det` resets it. A check byte passes when the register equals 0x00 after that byte has been absorbed.
- R5: In slave receive mode (`master_mode`=0), a check byte that fails gives a NACK whatever the value of `ack_dis`, and sets `crc_err`.
- R6: In master receive mode (`master_mode`=1), the acknowledge for a check byte follows only `ack_dis`. A failing check still sets `crc_err`.
- R7: `crc_err` stays at 1 until `start_det` or `crc_err_clr`. Either one clears it on the next clock.
- R8: A one-clock `pec_arm` pulse marks bytes as check bytes until the next `start_det` or reset. After a START, bytes are not checked.
- R9: With `rx_mode`=0 (transmit), `sda_pull` stays 0, `pec_arm` has no effect and `crc_err` is not set.
- R10: `sda_pull` changes only on clocks where `scl_in` is low, except for the release forced by `start_det`, `stop_det` or reset.
- R11: After reset, `sda_pull`, `crc_err` and `rx_valid` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| scl_in | input | 1 | Synchronised SCL level |
| sda_in | input | 1 | Synchronised SDA level |
| start_det | input | 1 | One-clock START / repeated START strobe |
| stop_det | input | 1 | One-clock STOP strobe |
| rx_mode | input | 1 | 1 = block is receiving, 0 = transmitting |
| master_mode | input | 1 | 1 = master, 0 = slave |
| ack_dis | input | 1 | 1 = answer received bytes with NACK |
| pec_arm | input | 1 | One-clock pulse: following bytes are check bytes |
| crc_err_clr | input | 1 | One-clock pulse clearing `crc_err` |
| rx_data | output | DATA_W | Last received byte |
| rx_valid | output | 1 | One-clock byte-done strobe |
| crc_err | output | 1 | Sticky check-failure flag |
| sda_pull | output | 1 | 1 = pull SDA low |

## Verification
The bench sends a check byte that is one bit off in slave and master modes. A design that mixes up the two rules would acknowledge the bad byte in slave mode, or withhold the acknowledge in master mode. The bench issues a repeated START in mid-transfer and then sends a check byte computed only over the bytes after it. A CRC that is not reset there would NACK this correct byte. It also arms the check and issues a START before the next byte, which catches a flag that survives the START. It also arms the check in transmit mode, where a leaking flag would drive SDA or raise the error flag.

// File: rtl/i2c_pec_pkg.sv
package i2c_pec_pkg;
  localparam int CRC_W = 8;
  typedef logic [CRC_W-1:0] crc_t;

  // one bit of an MSB-first CRC shift
  function automatic crc_t crc_bit(input crc_t cur, input logic din, input crc_t poly);
    logic fb;
    fb = cur[CRC_W-1] ^ din;
    return {cur[CRC_W-2:0], 1'b0} ^ (fb ? poly : '0);
  endfunction
endpackage

// File: rtl/i2c_rx_shifter.sv
module i2c_rx_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl,
  input  logic              sda,
  input  logic              start_det,
  input  logic              stop_det,
  output logic              samp_en,
  output logic              last_bit,
  output logic              ack_slot,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid
);
  localparam int CNT_W = $clog2(DATA_W + 2);
  localparam logic [CNT_W-1:0] LAST_IDX = CNT_W'(DATA_W - 1);
  localparam logic [CNT_W-1:0] ACK_IDX  = CNT_W'(DATA_W);
  localparam logic [CNT_W-1:0] DONE_IDX = CNT_W'(DATA_W + 1);

  logic             scl_q;
  logic [CNT_W-1:0] cnt;
  logic [DATA_W-1:0] sreg, sreg_nx;
  logic             rise;

  assign rise     = scl & ~scl_q;
  assign samp_en  = rise && (cnt < ACK_IDX);
  assign last_bit = samp_en && (cnt == LAST_IDX);
  assign ack_slot = (cnt == ACK_IDX);
  assign sreg_nx  = {sreg[DATA_W-2:0], sda};

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      scl_q    <= 1'b1;
      cnt      <= '0;
      sreg     <= '0;
      rx_data  <= '0;
      rx_valid <= 1'b0;
    end else begin
      scl_q    <= scl;
      rx_valid <= 1'b0;
      if (start_det || stop_det) begin
        cnt <= '0;
      end else if (samp_en) begin
        sreg <= sreg_nx;
        cnt  <= cnt + 1'b1;
        if (last_bit) begin
          rx_data  <= sreg_nx;
          rx_valid <= 1'b1;
        end
      end else if (rise && ack_slot) begin
        cnt <= DONE_IDX;
      end else if (!scl && (cnt == DONE_IDX)) begin
        cnt <= '0;
      end
    end
  end
endmodule

// File: rtl/pec_crc8.sv
module pec_crc8
  import i2c_pec_pkg::*;
#(
  parameter crc_t POLY = 8'h07,
  parameter crc_t INIT = 8'h00
) (
  input  logic clk,
  input  logic rst_n,
  input  logic clr,
  input  logic en,
  input  logic bit_in,
  output crc_t crc_nx
);
  crc_t crc_q;

  assign crc_nx = en ? crc_bit(crc_q, bit_in, POLY) : crc_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   crc_q <= INIT;
    else if (clr) crc_q <= INIT;
    else          crc_q <= crc_nx;
  end
endmodule

// File: rtl/pec_ack_ctrl.sv
module pec_ack_ctrl
  import i2c_pec_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic scl,
  input  logic start_det,
  input  logic stop_det,
  input  logic pec_arm,
  input  logic err_clr,
  input  logic rx_mode,
  input  logic master_mode,
  input  logic ack_dis,
  input  logic last_bit,
  input  logic ack_slot,
  input  crc_t crc_nx,
  output logic sda_pull,
  output logic crc_err
);
  logic pec_flag;
  logic ack_pend;
  logic chk_fail;
  logic ack_ok;

  // the check only applies to armed bytes received in receive mode
  assign chk_fail = pec_flag && rx_mode && (crc_nx != '0);
  assign ack_ok   = rx_mode && !ack_dis && !(chk_fail && !master_mode);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      pec_flag <= 1'b0;
      ack_pend <= 1'b0;
      sda_pull <= 1'b0;
      crc_err  <= 1'b0;
    end else if (start_det) begin
      pec_flag <= 1'b0;
      ack_pend <= 1'b0;
      sda_pull <= 1'b0;
      crc_err  <= 1'b0;
    end else begin
      if (pec_arm) pec_flag <= 1'b1;
      if (last_bit) begin
        ack_pend <= ack_ok;
        if (chk_fail) crc_err <= 1'b1;
      end else if (err_clr) begin
        crc_err <= 1'b0;
      end
      if (stop_det)  sda_pull <= 1'b0;
      else if (!scl) sda_pull <= ack_slot && ack_pend;
    end
  end
endmodule

// File: rtl/i2c_pec_rx.sv
module i2c_pec_rx
  import i2c_pec_pkg::*;
#(
  parameter int   DATA_W   = 8,
  parameter crc_t CRC_POLY = 8'h07,
  parameter crc_t CRC_INIT = 8'h00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              scl_in,
  input  logic              sda_in,
  input  logic              start_det,
  input  logic              stop_det,
  input  logic              rx_mode,
  input  logic              master_mode,
  input  logic              ack_dis,
  input  logic              pec_arm,
  input  logic              crc_err_clr,
  output logic [DATA_W-1:0] rx_data,
  output logic              rx_valid,
  output logic              crc_err,
  output logic              sda_pull
);
  logic samp_en, last_bit, ack_slot;
  crc_t crc_nx;

  i2c_rx_shifter #(.DATA_W(DATA_W)) u_shift (
    .clk(clk), .rst_n(rst_n), .scl(scl_in), .sda(sda_in),
    .start_det(start_det), .stop_det(stop_det),
    .samp_en(samp_en), .last_bit(last_bit), .ack_slot(ack_slot),
    .rx_data(rx_data), .rx_valid(rx_valid)
  );

  pec_crc8 #(.POLY(CRC_POLY), .INIT(CRC_INIT)) u_crc (
    .clk(clk), .rst_n(rst_n), .clr(start_det), .en(samp_en),
    .bit_in(sda_in), .crc_nx(crc_nx)
  );

  pec_ack_ctrl u_ack (
    .clk(clk), .rst_n(rst_n), .scl(scl_in), .start_det(start_det),
    .stop_det(stop_det), .pec_arm(pec_arm), .err_clr(crc_err_clr),
    .rx_mode(rx_mode), .master_mode(master_mode), .ack_dis(ack_dis),
    .last_bit(last_bit), .ack_slot(ack_slot), .crc_nx(crc_nx),
    .sda_pull(sda_pull), .crc_err(crc_err)
  );
endmodule

// File: rtl/i2c_pec_rx_chk.sv
module i2c_pec_rx_chk (
  input logic clk,
  input logic rst_n,
  input logic scl_in,
  input logic start_det,
  input logic stop_det,
  input logic rx_mode,
  input logic ack_dis,
  input logic crc_err_clr,
  input logic rx_valid,
  input logic crc_err,
  input logic sda_pull
);
  // a NACK is owed for the byte that just completed
  logic nack_owed;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) nack_owed <= 1'b0;
    else if (start_det || stop_det) nack_owed <= 1'b0;
    else if (rx_valid) nack_owed <= $past(ack_dis) || $past(!rx_mode);
  end

  // R1: byte-done strobe lasts one clock
  p_valid_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R3 / R9: no pull when the byte must be refused
  p_nack_hold_r3: assert property (@(posedge clk) disable iff (!rst_n)
    nack_owed |-> !sda_pull);

  // R7: error flag holds without a clearing event
  p_err_sticky_r7: assert property (@(posedge clk) disable iff (!rst_n)
    crc_err && !start_det && !crc_err_clr |=> crc_err);

  // R7: START clears flag and releases SDA
  p_start_clear_r7: assert property (@(posedge clk) disable iff (!rst_n)
    start_det |=> !crc_err && !sda_pull);

  // R10: SDA drive moves only while SCL is low
  p_pull_scl_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) && !$past(start_det) && !$past(stop_det)
      |-> !$past(scl_in));
endmodule

bind i2c_pec_rx i2c_pec_rx_chk u_chk (.*);

// File: tb/test_i2c_pec_rx.sv
module test_i2c_pec_rx;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic scl_in = 1'b1, sda_in = 1'b1;
  logic start_det = 1'b0, stop_det = 1'b0;
  logic rx_mode = 1'b1, master_mode = 1'b0, ack_dis = 1'b0;
  logic pec_arm = 1'b0, crc_err_clr = 1'b0;
  logic [7:0] rx_data;
  logic rx_valid, crc_err, sda_pull;

  int n_chk = 0;
  int n_fail = 0;
  logic [7:0] exp_q[$];
  logic [7:0] tb_crc = 8'h00;

  always #10 clk = ~clk;

  i2c_pec_rx i_i2c_pec_rx (.*);

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] crc_byte(input logic [7:0] c, input logic [7:0] b);
    logic [7:0] r;
    r = c ^ b;
    for (int k = 0; k < 8; k++) r = r[7] ? ((r << 1) ^ 8'h07) : (r << 1);
    return r;
  endfunction

  task automatic do_start();
    start_det = 1'b1; tick(1); start_det = 1'b0; tick(1);
    tb_crc = 8'h00;
  endtask

  task automatic do_stop();
    stop_det = 1'b1; tick(1); stop_det = 1'b0; tick(1);
  endtask

  task automatic pulse_arm();
    pec_arm = 1'b1; tick(1); pec_arm = 1'b0;
  endtask

  // driver: pushes the expected byte, clocks it in, checks the 9th clock
  task automatic send_byte(input logic [7:0] b, input logic exp_ack, input string req);
    exp_q.push_back(b);
    for (int i = 7; i >= 0; i--) begin
      scl_in = 1'b0; tick(2); sda_in = b[i]; tick(2);
      scl_in = 1'b1; tick(4);
    end
    tb_crc = crc_byte(tb_crc, b);
    scl_in = 1'b0; sda_in = 1'b1; tick(4);
    chk(sda_pull == exp_ack, req, sda_pull, exp_ack);
    scl_in = 1'b1; tick(4);
    chk(sda_pull == exp_ack, "R10 hold in 9th high", sda_pull, exp_ack);
    scl_in = 1'b0; tick(4);
    chk(sda_pull == 1'b0, "R2 release", sda_pull, 0);
  endtask

  // monitor: compares each completed byte with the queue
  always @(negedge clk) begin
    if (rx_valid) begin
      if (exp_q.size() == 0) chk(1'b0, "R1 unexpected byte", rx_data, 0);
      else begin
        logic [7:0] e;
        e = exp_q.pop_front();
        chk(rx_data == e, "R1 byte data", rx_data, e);
      end
    end
  end

  task automatic finish_test();
    chk(exp_q.size() == 0, "R1 bytes missing", exp_q.size(), 0);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    tick(3);
    chk(sda_pull == 0, "R11 pull", sda_pull, 0);
    chk(crc_err == 0, "R11 err", crc_err, 0);
    chk(rx_valid == 0, "R11 valid", rx_valid, 0);
    rst_n = 1'b1; tick(2);

    // R2 / R1: plain slave receive
    do_start();
    send_byte(8'hA4, 1'b1, "R2 ack");
    send_byte(8'h3C, 1'b1, "R2 ack second");
    // R3: acknowledge disabled
    ack_dis = 1'b1;
    send_byte(8'h5A, 1'b0, "R3 nack");
    ack_dis = 1'b0;
    do_stop();

    // R4: good check byte in slave mode
    do_start();
    send_byte(8'hA4, 1'b1, "R4 addr");
    send_byte(8'h11, 1'b1, "R4 data");
    send_byte(8'hF0, 1'b1, "R4 data");
    pulse_arm();
    send_byte(tb_crc, 1'b1, "R4 good pec ack");
    chk(crc_err == 0, "R4 no error", crc_err, 0);

    // R5: bad check byte in slave mode
    do_start();
    send_byte(8'hA4, 1'b1, "R5 addr");
    send_byte(8'h22, 1'b1, "R5 data");
    pulse_arm();
    send_byte(tb_crc ^ 8'h01, 1'b0, "R5 bad pec nack");
    chk(crc_err == 1, "R5 error set", crc_err, 1);

    // R7: sticky, then cleared by software
    do_stop(); tick(5);
    chk(crc_err == 1, "R7 sticky", crc_err, 1);
    crc_err_clr = 1'b1; tick(1); crc_err_clr = 1'b0; tick(1);
    chk(crc_err == 0, "R7 clear", crc_err, 0);

    // R6: master mode ignores check result for the acknowledge
    master_mode = 1'b1;
    do_start();
    send_byte(8'h55, 1'b1, "R6 data");
    pulse_arm();
    send_byte(tb_crc ^ 8'h80, 1'b1, "R6 bad pec still ack");
    chk(crc_err == 1, "R6 error set", crc_err, 1);
    ack_dis = 1'b1;
    send_byte(8'h0F, 1'b0, "R6 follows ack_dis");
    ack_dis = 1'b0;
    do_start();
    chk(crc_err == 0, "R7 start clears", crc_err, 0);
    master_mode = 1'b0;

    // R8: START disarms the check flag
    pulse_arm();
    do_start();
    send_byte(8'h77, 1'b1, "R8 disarmed ack");
    chk(crc_err == 0, "R8 no error", crc_err, 0);

    // R4: repeated START restarts the CRC
    do_start();
    send_byte(8'h12, 1'b1, "R4 pre-restart");
    send_byte(8'h34, 1'b1, "R4 pre-restart");
    do_start();
    send_byte(8'hA5, 1'b1, "R4 after restart");
    pulse_arm();
    send_byte(tb_crc, 1'b1, "R4 restart pec ack");
    chk(crc_err == 0, "R4 restart no error", crc_err, 0);

    // R9: transmit mode ignores the check flag and never pulls
    do_start();
    rx_mode = 1'b0;
    pulse_arm();
    send_byte(8'h99, 1'b0, "R9 tx no pull");
    send_byte(8'h98, 1'b0, "R9 tx no pull");
    chk(crc_err == 0, "R9 no error", crc_err, 0);
    rx_mode = 1'b1;
    do_start();
    do_stop();
    tick(4);
    finish_test();
  end
endmodule